// File: doc/BRIEF.md
# Random Word Output Buffer

This block sits between a random-number conditioning core and the data register that software reads. The core offers 32-bit words over a valid/ready handshake; the buffer collects them into a four-entry first-in first-out store. Once the store is full it raises a data-ready flag, and the reader may then take up to four words in a row, each read popping a fresh word. The buffer does not refill until the burst has been fully drained.

Error handling sits on the read side. While a seed error is signalled, or when the core hands over a word of all zeros (a late seed error), every held word is thrown away. Reads then return zero, and generation stays halted until a fixed number of data reads (twelve by default) have been discarded to empty the upstream pipeline. A soft reset also empties the store, and it clears that discard requirement at once. Dropping the enable input empties the store and refuses new words.

Top module: `rng_wordbuf`

## Requirements
- R1: After reset, data_ready is low, rd_data is zero and, with enable high and no error or soft reset, in_ready is high.
- R2: A word is taken only in a cycle where in_valid and in_ready are both high. in_ready is high only when enable is high, soft_rst and seed_err are low, no discard reads are pending, data_ready is low and fewer than four words are held.
- R3: data_ready rises in the cycle after the fourth word is taken and is never high with fewer than four words held.
- R4: While data_ready is high, each read (rd_en high) shows the oldest held word on rd_data and removes it, in first-in first-out order. data_ready falls in the cycle after the fourth read. No word is taken while data_ready is high.
- R5: A read while data_ready is low returns zero, removes nothing and leaves the held words and data_ready unchanged.
- R6: While seed_err is high, rd_data is zero and in_ready is low. In the next cycle all held words are gone and data_ready is low.
- R7: After a seed error, 12 reads (counted while seed_err is low) must be made before in_ready can rise again. Each of those reads returns zero.
- R8: A word of all zeros taken from the core is never stored. It flushes the buffer and starts the same 12-read discard as a seed error.
- R9: While enable is low, in_ready is low, and in the next cycle the buffer is empty with data_ready low.
- R10: A soft reset (soft_rst high) makes in_ready and rd_data zero in that cycle. In the next cycle the buffer is empty, data_ready is low and any pending discard reads are cancelled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; low empties the buffer |
| soft_rst | input | 1 | Soft reset: flush and cancel pending discards |
| seed_err | input | 1 | Seed error from the entropy source, level |
| in_valid | input | 1 | Core offers a word |
| in_data | input | 32 | Word from the core |
| in_ready | output | 1 | Buffer accepts the offered word |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 32 | Word returned by this cycle's read, zero when none is valid |
| data_ready | output | 1 | Four words are held and may be read |

## Verification
The bench targets burst edges. A design that raised data_ready early would return zeros or stale words partway through the burst. One that refilled during a burst would show the wrong order or a fifth word. After a seed error it counts discard reads to the exact cycle. A counter that is off by one reopens in_ready one read early or late, and one that counts reads made during the error reopens far too soon. It injects zero words from the core, where a design that stored them would hand out a zero as valid data. It also drops enable, pulses soft reset and reads while empty, mixed randomly with errors at every point of a fill or burst.

// File: rtl/rng_wordbuf_pkg.sv
package rng_wordbuf_pkg;

    // What the buffer does this cycle, in priority order
    typedef enum logic [1:0] {
        BUF_RUN      = 2'd0,
        BUF_IDLE     = 2'd1,
        BUF_SEED_ERR = 2'd2,
        BUF_SOFT_RST = 2'd3
    } buf_act_e;

endpackage

// File: rtl/rng_wordbuf_store.sv
module rng_wordbuf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd_ptr;
        logic [PTR_W-1:0]             wr_ptr;
        logic [CNT_W-1:0]             count;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (push_i) begin
                st_d.mem[st_q.wr_ptr] = wdata_i;
                st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
            end
            if (pop_i) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            end
            st_d.count = st_q.count + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd_ptr];
    assign count_o = st_q.count;

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && st_q.count == '0));
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (st_q.count < CNT_W'(DEPTH)));
    // R8
    nonzero_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (wdata_i != '0));

endmodule

// File: rtl/rng_wordbuf_discard.sv
module rng_wordbuf_discard
    import rng_wordbuf_pkg::*;
#(
    parameter int DISCARD_WORDS = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  buf_act_e act_i,
    input  logic     rd_i,
    output logic     busy_o
);
    localparam int LEFT_W = $clog2(DISCARD_WORDS + 1);

    typedef struct packed {
        logic [LEFT_W-1:0] left;
    } disc_t;

    disc_t dc_d, dc_q;

    always_comb begin
        dc_d = dc_q;
        case (act_i)
            BUF_SEED_ERR: dc_d.left = LEFT_W'(DISCARD_WORDS);
            BUF_SOFT_RST: dc_d.left = '0;
            default: begin
                if (rd_i && dc_q.left != '0) dc_d.left = dc_q.left - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dc_q <= '0;
        else        dc_q <= dc_d;
    end

    assign busy_o = (dc_q.left != '0);

    // R7
    discard_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == BUF_SEED_ERR) |=> (dc_q.left == LEFT_W'(DISCARD_WORDS)));
    // R7
    discard_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == BUF_RUN && rd_i && busy_o) |=> (dc_q.left == $past(dc_q.left) - 1'b1));
    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == BUF_SOFT_RST) |=> !busy_o);

endmodule

// File: rtl/rng_wordbuf.sv
module rng_wordbuf
    import rng_wordbuf_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int DEPTH         = 4,
    parameter int DISCARD_WORDS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              soft_rst,
    input  logic              seed_err,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic drdy;
    } top_t;

    top_t      tp_d, tp_q;
    buf_act_e  act;
    logic      disc_busy;
    logic      push, pop, take;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  fill_count;

    always_comb begin
        in_ready = enable && !soft_rst && !seed_err && !disc_busy &&
                   !tp_q.drdy && (fill_count < CNT_W'(DEPTH));
        take     = in_valid && in_ready;

        if (soft_rst)                               act = BUF_SOFT_RST;
        else if (seed_err || (take && in_data == '0)) act = BUF_SEED_ERR;
        else if (!enable)                           act = BUF_IDLE;
        else                                        act = BUF_RUN;

        push = (act == BUF_RUN) && take;
        pop  = (act == BUF_RUN) && rd_en && tp_q.drdy;

        tp_d = tp_q;
        if (act != BUF_RUN)                                tp_d.drdy = 1'b0;
        else if (push && fill_count == CNT_W'(DEPTH - 1)) tp_d.drdy = 1'b1;
        else if (pop && fill_count == CNT_W'(1))           tp_d.drdy = 1'b0;

        rd_data = (tp_q.drdy && !seed_err && !soft_rst) ? head : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign data_ready = tp_q.drdy;

    rng_wordbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (act != BUF_RUN),
        .push_i  (push),
        .wdata_i (in_data),
        .pop_i   (pop),
        .head_o  (head),
        .count_o (fill_count)
    );

    rng_wordbuf_discard #(.DISCARD_WORDS(DISCARD_WORDS)) u_discard (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .rd_i   (rd_en),
        .busy_o (disc_busy)
    );

    // R3
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> (fill_count == CNT_W'(DEPTH)));
    // R6
    seed_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err |=> (!data_ready && fill_count == '0));
    // R4
    nonzero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && rd_en && !seed_err && !soft_rst) |-> (rd_data != '0));
    // R9
    disable_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (fill_count == '0 && !data_ready));

endmodule

// File: tb/rng_wordbuf_bench.sv
module rng_wordbuf_bench;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int DISC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable, soft_rst, seed_err, in_valid, rd_en;
    logic [DW-1:0] in_data;
    logic in_ready, data_ready;
    logic [DW-1:0] rd_data;

    always #5 clk = ~clk;

    rng_wordbuf u_rng_wordbuf (
        .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
        .seed_err(seed_err), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rd_en(rd_en), .rd_data(rd_data),
        .data_ready(data_ready)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [DW-1:0] m_buf [DEPTH];
    int m_cnt = 0;
    int m_disc = 0;
    bit m_drdy = 0;
    bit m_zero_src = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_ready();
        return enable && !soft_rst && !seed_err && m_disc == 0 && !m_drdy && m_cnt < DEPTH;
    endfunction

    function automatic logic [DW-1:0] exp_rd();
        return (m_drdy && !seed_err && !soft_rst) ? m_buf[0] : '0;
    endfunction

    task automatic set_in(input logic en, input logic sr, input logic se,
                          input logic iv, input logic [DW-1:0] d, input logic rd);
        enable = en; soft_rst = sr; seed_err = se; in_valid = iv; in_data = d; rd_en = rd;
    endtask

    // Check outputs mid-cycle, then advance the model across the edge
    task automatic tick();
        string rtag;
        bit acc, pop;
        #2;
        rtag = soft_rst ? "R10" : seed_err ? "R6" : !enable ? "R9" :
               (m_disc != 0) ? (m_zero_src ? "R8" : "R7") : m_drdy ? "R4" : "R2";
        chk(rtag, DW'(in_ready), DW'(exp_ready()));
        chk("R3", DW'(data_ready), DW'(m_drdy));
        if (rd_en) chk(seed_err ? "R6" : m_drdy ? "R4" : "R5", rd_data, exp_rd());
        acc = in_valid && exp_ready();
        pop = rd_en && m_drdy && !seed_err && !soft_rst;
        @(posedge clk);
        if (soft_rst) begin
            m_cnt = 0; m_drdy = 0; m_disc = 0;
        end else if (seed_err || (acc && in_data == '0)) begin
            m_cnt = 0; m_drdy = 0; m_disc = DISC; m_zero_src = !seed_err;
        end else begin
            if (rd_en && m_disc > 0) m_disc--;
            if (!enable) begin
                m_cnt = 0; m_drdy = 0;
            end else begin
                if (pop) begin
                    for (int i = 0; i < DEPTH - 1; i++) m_buf[i] = m_buf[i+1];
                    m_cnt--;
                    if (m_cnt == 0) m_drdy = 0;
                end
                if (acc) begin
                    m_buf[m_cnt] = in_data;
                    m_cnt++;
                    if (m_cnt == DEPTH) m_drdy = 1;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual run hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0713));
        set_in(1, 0, 0, 0, '0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1", DW'(data_ready), '0);
        chk("R1", DW'(in_ready), 32'd1);
        chk("R1", rd_data, '0);
        @(negedge clk);

        // R5: read while empty
        set_in(1, 0, 0, 0, '0, 1); tick();
        // R3/R4: fill four, read four in order
        for (int i = 0; i < 4; i++) begin set_in(1, 0, 0, 1, 32'hA000_0001 + i, 0); tick(); end
        set_in(1, 0, 0, 1, 32'hBEEF_0000, 0); tick();
        for (int i = 0; i < 5; i++) begin set_in(1, 0, 0, 1, 32'h1234_5678, 1); tick(); end
        // R6/R7: seed error mid-fill, then discard reads
        set_in(1, 0, 0, 1, 32'h0000_0055, 0); tick();
        set_in(1, 0, 1, 1, 32'h0000_0066, 1); tick();
        for (int i = 0; i < 13; i++) begin set_in(1, 0, 0, 1, 32'h0000_0100 + i, 1); tick(); end
        // R8: zero word from the core
        set_in(1, 0, 0, 1, 32'h0000_0000, 0); tick();
        for (int i = 0; i < 6; i++) begin set_in(1, 0, 0, 1, 32'h0000_0200 + i, 0); tick(); end
        // R10: soft reset cancels pending discard
        set_in(1, 1, 0, 0, '0, 0); tick();
        for (int i = 0; i < 4; i++) begin set_in(1, 0, 0, 1, 32'hC000_0000 + i, 0); tick(); end
        // R9: enable low with a full burst held
        set_in(0, 0, 0, 1, 32'h0000_0777, 1); tick();
        set_in(1, 0, 0, 0, '0, 1); tick();

        for (int c = 0; c < 4000; c++) begin
            set_in(($urandom % 20) != 0, ($urandom % 64) == 0, ($urandom % 48) == 0,
                   ($urandom % 10) < 7, (($urandom % 24) == 0) ? '0 : DW'($urandom),
                   ($urandom % 10) < 4);
            tick();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule